// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block turns indirect memory accesses into effective data addresses. It holds a small file of offset pointers, one shared buffer start address and one shared buffer length. Each pointer has its own mode bit. When the bit is set, the pointer is an offset into a ring buffer. The effective address is then the start address plus the offset, and the offset wraps inside the ring after each use. When the bit is clear, the pointer is a plain address. It is used as is and moves linearly.

Software sets up the start address, the length, the offsets and the mode bits through a single-cycle write port. An access request names a pointer and a post-modify operation. The block registers the effective address, raises `addr_valid` on the next cycle, and writes the modified offset back into the pointer file.

A two-state sequencer drives the output qualifier. `ST_IDLE` means no address is presented. `ST_ISSUE` means the address register holds a fresh result. There are three transitions:
- `ST_IDLE` to `ST_ISSUE` on an access request.
- `ST_ISSUE` to `ST_ISSUE` on a back-to-back request.
- `ST_ISSUE` to `ST_IDLE` when no request arrives.

Top module: `circ_agen`

## Requirements
- R1: After reset, all offsets, the start address, the length and the mode bits are zero, `addr_valid` is 0 and `addr` is 0.
- R2: A write with `wr_en`=1 updates one field on the next rising edge, selected by `wr_sel`: 0 sets the offset of pointer `wr_idx` from `wr_data[15:0]`, 1 sets the start address from `wr_data[23:0]`, 2 sets the length from `wr_data[15:0]`, 3 sets the mode bit of pointer `wr_idx` from `wr_data[0]`, where 1 means circular.
- R3: `addr_valid` is 1 in the cycle after each cycle with `acc_valid`=1 and is 0 after any cycle without a request.
- R4: For a pointer in circular mode, `addr` equals the start address plus the zero-extended offset, modulo 2^24.
- R5: For a pointer in linear mode, `addr` equals the zero-extended offset, and the start address has no effect.
- R6: In circular mode, increment (`acc_op`=1) moves the offset from length-1 to 0. With length 4 and offset 2, four increments present offsets 2, 3, 0, 1.
- R7: In circular mode, decrement (`acc_op`=2) moves the offset from 0 to length-1.
- R8: `acc_op`=0 leaves the offset unchanged. `acc_op`=3 adds the signed 16-bit `acc_step`. In circular mode the result is folded into 0..length-1, provided |step| does not exceed the length and the offset is below it.
- R9: In linear mode, updates wrap modulo 2^16 (0xFFFF incremented gives 0x0000).
- R10: When a write to a pointer's offset and an access to the same pointer happen in one cycle, the written value is kept. The presented address uses the pre-write offset.
- R11: An access modifies only the selected pointer. All other offsets keep their values.
- R12: In circular mode with a length of 0, the offset is held whatever `acc_op` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select for the write |
| wr_idx | input | 2 | Pointer index for offset/mode writes |
| wr_data | input | 24 | Write data |
| acc_valid | input | 1 | Access request |
| acc_idx | input | 2 | Pointer used by the access |
| acc_op | input | 2 | Post-modify operation |
| acc_step | input | 16 | Signed step for `acc_op`=3 |
| addr_valid | output | 1 | Effective address is valid |
| addr | output | 24 | Effective address |

## Verification
The first stimulus is a run of increments across the ring end, with length 4 starting at offset 2. It separates a correct modulo fold from a linear count, and from an off-by-one wrap at the length. Decrements from offset 0 and signed steps of +3 and -2 check both fold directions. Linear pointers are tried at 0xFFFF with a non-zero start address, which shows both that the start address is dropped and that the counter rolls over at 16 bits. Same-cycle write and access, accesses to one pointer followed by a read of another, and a zero length each isolate one priority or independence rule.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_BASE = 2'd1,
        SEL_SIZE = 2'd2,
        SEL_MODE = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_STEP = 2'd3
    } mod_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } agen_state_e;

endpackage

// File: rtl/circ_agen_update.sv
module circ_agen_update
    import circ_agen_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [OFS_W-1:0] size,
    input  logic             circ,
    input  logic [1:0]       op,
    input  logic [OFS_W-1:0] step,
    output logic [OFS_W-1:0] nxt
);
    localparam int EXT_W = OFS_W + 2;

    logic signed [EXT_W-1:0] delta;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] sz;
    logic signed [EXT_W-1:0] folded;
    logic        [OFS_W-1:0] lin;

    always_comb begin
        unique case (mod_op_e'(op))
            OP_HOLD: delta = '0;
            OP_INC:  delta = EXT_W'(1);
            OP_DEC:  delta = -EXT_W'(1);
            OP_STEP: delta = {{2{step[OFS_W-1]}}, step};
            default: delta = '0;
        endcase
    end

    always_comb begin
        lin = ofs + delta[OFS_W-1:0];
        sum = $signed({2'b00, ofs}) + delta;
        sz  = $signed({2'b00, size});
        if (sum < 0)
            folded = sum + sz;
        else if (sum >= sz)
            folded = sum - sz;
        else
            folded = sum;
    end

    always_comb begin
        if (!circ)
            nxt = lin;
        else if (size == '0)
            nxt = ofs;
        else
            nxt = folded[OFS_W-1:0];
    end

    // R6 R7
    always_comb begin
        if (circ && size != '0 && ofs < size && op != OP_STEP) begin
            wrap_range_chk: assert (nxt < size)
                else $error("circular offset left the ring");
        end
    end

endmodule

// File: rtl/circ_agen_regs.sv
module circ_agen_regs
    import circ_agen_pkg::*;
#(
    parameter int NUM_PTR = 4,
    parameter int OFS_W   = 16,
    parameter int ADDR_W  = 24,
    parameter int IDX_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [ADDR_W-1:0]             wr_data,
    input  logic                          upd_en,
    input  logic [IDX_W-1:0]              upd_idx,
    input  logic [OFS_W-1:0]              upd_val,
    output logic [NUM_PTR-1:0][OFS_W-1:0] ofs_q,
    output logic [ADDR_W-1:0]             base_q,
    output logic [OFS_W-1:0]              size_q,
    output logic [NUM_PTR-1:0]            circ_q
);
    logic wr_ptr;
    logic wr_base;
    logic wr_size;
    logic wr_mode;

    always_comb begin
        wr_ptr  = wr_en && (wr_sel_e'(wr_sel) == SEL_PTR);
        wr_base = wr_en && (wr_sel_e'(wr_sel) == SEL_BASE);
        wr_size = wr_en && (wr_sel_e'(wr_sel) == SEL_SIZE);
        wr_mode = wr_en && (wr_sel_e'(wr_sel) == SEL_MODE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else begin
            if (wr_base) base_q <= wr_data;
            if (wr_size) size_q <= wr_data[OFS_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        logic hit_wr;
        logic hit_upd;

        always_comb begin
            hit_wr  = wr_ptr && (wr_idx == IDX_W'(i));
            hit_upd = upd_en && (upd_idx == IDX_W'(i));
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                ofs_q[i] <= '0;
            else if (hit_wr)
                ofs_q[i] <= wr_data[OFS_W-1:0];
            else if (hit_upd)
                ofs_q[i] <= upd_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                circ_q[i] <= 1'b0;
            else if (wr_mode && wr_idx == IDX_W'(i))
                circ_q[i] <= wr_data[0];
        end

        // R10
        write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_PTR && wr_idx == IDX_W'(i))
            |=> (ofs_q[i] == $past(wr_data[OFS_W-1:0])))
            else $error("pointer write lost");

        // R11
        untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_sel == SEL_PTR && wr_idx == IDX_W'(i)) &&
             !(upd_en && upd_idx == IDX_W'(i)))
            |=> $stable(ofs_q[i]))
            else $error("unselected pointer changed");
    end

endmodule

// File: rtl/circ_agen_addr.sv
module circ_agen_addr #(
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [ADDR_W-1:0] base,
    input  logic              circ,
    output logic [ADDR_W-1:0] eff
);
    localparam int PAD_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{PAD_W{1'b0}}, ofs};
        eff     = circ ? (base + ofs_ext) : ofs_ext;
    end

endmodule

// File: rtl/circ_agen.sv
module circ_agen
    import circ_agen_pkg::*;
#(
    parameter int NUM_PTR = 4,
    parameter int OFS_W   = 16,
    parameter int ADDR_W  = 24,
    parameter int IDX_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [1:0]        acc_op,
    input  logic [OFS_W-1:0]  acc_step,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - OFS_W;

    logic [NUM_PTR-1:0][OFS_W-1:0] ofs_q;
    logic [ADDR_W-1:0]             base_q;
    logic [OFS_W-1:0]              size_q;
    logic [NUM_PTR-1:0]            circ_q;
    logic [OFS_W-1:0]              ofs_sel;
    logic                          circ_sel;
    logic [OFS_W-1:0]              ofs_nxt;
    logic [ADDR_W-1:0]             eff;
    logic [ADDR_W-1:0]             addr_q;
    agen_state_e                   state_q;
    agen_state_e                   state_d;

    always_comb begin
        ofs_sel  = ofs_q[acc_idx];
        circ_sel = circ_q[acc_idx];
    end

    circ_agen_regs #(
        .NUM_PTR (NUM_PTR),
        .OFS_W   (OFS_W),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (acc_valid),
        .upd_idx (acc_idx),
        .upd_val (ofs_nxt),
        .ofs_q   (ofs_q),
        .base_q  (base_q),
        .size_q  (size_q),
        .circ_q  (circ_q)
    );

    circ_agen_update #(
        .OFS_W (OFS_W)
    ) u_update (
        .ofs  (ofs_sel),
        .size (size_q),
        .circ (circ_sel),
        .op   (acc_op),
        .step (acc_step),
        .nxt  (ofs_nxt)
    );

    circ_agen_addr #(
        .OFS_W  (OFS_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .ofs  (ofs_sel),
        .base (base_q),
        .circ (circ_sel),
        .eff  (eff)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = acc_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = acc_valid ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (acc_valid)
            addr_q <= eff;
    end

    // outputs
    always_comb begin
        addr_valid = (state_q == ST_ISSUE);
        addr       = addr_q;
    end

    // R3
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> addr_valid)
        else $error("address not flagged after request");

    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !addr_valid)
        else $error("address flagged without request");

    // R5
    linear_no_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !circ_sel) |=> (addr[ADDR_W-1:OFS_W] == '0))
        else $error("linear address carries high bits");

    // R4
    circ_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && circ_sel && size_q != '0 && ofs_sel < size_q)
        |=> ((addr - $past(base_q)) < {{PAD_W{1'b0}}, $past(size_q)}))
        else $error("circular address outside ring");

endmodule

// File: tb/circ_agen_test.sv
module circ_agen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [1:0]  wr_idx;
    logic [23:0] wr_data;
    logic        acc_valid;
    logic [1:0]  acc_idx;
    logic [1:0]  acc_op;
    logic [15:0] acc_step;
    logic        addr_valid;
    logic [23:0] addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    circ_agen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx),
        .acc_op     (acc_op),
        .acc_step   (acc_step),
        .addr_valid (addr_valid),
        .addr       (addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] idx, input logic [23:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic acc(input string req, input logic [1:0] idx, input logic [1:0] op,
                       input logic [15:0] step, input logic [23:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = idx; acc_op = op; acc_step = step;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {8'h0, addr}, {8'h0, exp});
        check({req, " valid"}, {31'h0, addr_valid}, 32'h1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; acc_valid = 1'b0;
        wr_sel = '0; wr_idx = '0; wr_data = '0; acc_idx = '0; acc_op = '0; acc_step = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", {31'h0, addr_valid}, 32'h0);
        check("R1 addr", {8'h0, addr}, 32'h0);
        acc("R1 ptr zero", 2'd2, 2'd0, 16'h0, 24'h0);
    endtask

    task automatic t_ring_inc();
        wr(2'd1, 2'd0, 24'h001000);
        wr(2'd2, 2'd0, 24'h000004);
        wr(2'd3, 2'd0, 24'h000001);
        wr(2'd0, 2'd0, 24'h000002);
        wr(2'd3, 2'd2, 24'h000001);
        wr(2'd0, 2'd2, 24'h000001);
        acc("R6 R4 inc 2", 2'd0, 2'd1, 16'h0, 24'h001002);
        acc("R6 inc 3",    2'd0, 2'd1, 16'h0, 24'h001003);
        acc("R6 inc 0",    2'd0, 2'd1, 16'h0, 24'h001000);
        acc("R6 inc 1",    2'd0, 2'd1, 16'h0, 24'h001001);
        @(negedge clk);
        check("R3 idle low", {31'h0, addr_valid}, 32'h0);
        acc("R11 other ptr kept", 2'd2, 2'd0, 16'h0, 24'h001001);
    endtask

    task automatic t_ring_dec();
        wr(2'd0, 2'd0, 24'h000000);
        acc("R7 dec 0", 2'd0, 2'd2, 16'h0, 24'h001000);
        acc("R7 dec 3", 2'd0, 2'd2, 16'h0, 24'h001003);
        acc("R7 dec 2", 2'd0, 2'd0, 16'h0, 24'h001002);
    endtask

    task automatic t_step();
        wr(2'd3, 2'd1, 24'h000001);
        wr(2'd0, 2'd1, 24'h000001);
        acc("R8 step +3", 2'd1, 2'd3, 16'h0003, 24'h001001);
        acc("R8 step -2", 2'd1, 2'd3, 16'hFFFE, 24'h001000);
        acc("R8 hold",    2'd1, 2'd0, 16'h0,    24'h001002);
        acc("R8 hold again", 2'd1, 2'd0, 16'h0, 24'h001002);
    endtask

    task automatic t_linear();
        wr(2'd0, 2'd3, 24'h00FFFF);
        acc("R5 linear no base", 2'd3, 2'd1, 16'h0, 24'h00FFFF);
        acc("R9 linear rollover", 2'd3, 2'd0, 16'h0, 24'h000000);
        wr(2'd0, 2'd3, 24'h000009);
        acc("R9 linear dec", 2'd3, 2'd2, 16'h0, 24'h000009);
        acc("R9 linear past 4", 2'd3, 2'd1, 16'h0, 24'h000008);
        acc("R9 linear no wrap", 2'd3, 2'd0, 16'h0, 24'h000009);
        wr(2'd3, 2'd3, 24'h000001);
        wr(2'd0, 2'd3, 24'h000003);
        acc("R2 mode switch", 2'd3, 2'd0, 16'h0, 24'h001003);
        wr(2'd1, 2'd0, 24'hFFFFFE);
        acc("R4 address wraps", 2'd3, 2'd0, 16'h0, 24'h000001);
        wr(2'd1, 2'd0, 24'h001000);
    endtask

    task automatic t_priority();
        wr(2'd0, 2'd1, 24'h000001);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 2'd1; acc_op = 2'd1; acc_step = '0;
        wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 2'd1; wr_data = 24'h000003;
        @(negedge clk);
        acc_valid = 1'b0; wr_en = 1'b0;
        check("R10 old offset used", {8'h0, addr}, 32'h00001001);
        acc("R10 write kept", 2'd1, 2'd0, 16'h0, 24'h001003);
    endtask

    task automatic t_zero_size();
        wr(2'd2, 2'd0, 24'h000000);
        wr(2'd0, 2'd0, 24'h000002);
        acc("R12 size0 inc", 2'd0, 2'd1, 16'h0, 24'h001002);
        acc("R12 size0 dec", 2'd0, 2'd2, 16'h0, 24'h001002);
        acc("R12 size0 held", 2'd0, 2'd0, 16'h0, 24'h001002);
    endtask

    initial begin
        t_reset();
        t_ring_inc();
        t_ring_dec();
        t_step();
        t_linear();
        t_priority();
        t_zero_size();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule